// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Sequencer

This block sits between a synchronous host and an asynchronous static RAM with a 19-bit word address, a 16-bit data bus and active-low chip, output and write enables. The host offers one word at a time through a valid/ready handshake. The block then plays out a read or a write on the memory pins. Every strobe, the address and the write data come from registers, and each stays at its level for a whole number of clock cycles.

Each minimum time of the memory is a parameter given in picoseconds. The block converts it to a cycle count by dividing by the clock period parameter and rounding up. A read keeps chip enable and output enable low for the access time, samples the data bus while the address is still held, and then keeps the bus idle long enough for the memory to release it. A write keeps output enable high, so the shorter write-enable pulse applies. It drives the data bus one cycle before write enable falls and one cycle after write enable rises. Chip enable rises one cycle after write enable, so the write always ends on the write-enable edge.

The data bus is split into an output word, a drive-enable and an input word. The pad tristate sits outside the block.

Top module: `sram_ctl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is asserted, chip, output and write enable are high, the bus drive-enable is low, and req_ready and rsp_valid are low.
- R2: A request is taken only on a clock edge where req_valid and req_ready are both high. req_ready is low from the edge that takes a request until the operation ends, so a req_valid held high starts exactly one operation.
- R3: Define RD as the larger of ceil(T_ACC/T_CLK) and ceil(T_OE/T_CLK). For a read (req_write low), chip and output enable go low on the accepting edge and stay low for RD+1 cycles, with write enable high. rsp_valid is high for exactly one cycle, starting RD+1 edges after the accepting edge. rsp_rdata holds the word the memory gave at the addressed location.
- R4: Define TA as ceil(T_REL/T_CLK). After a read, chip and output enable go high and req_ready returns RD+1+TA edges after the accepting edge. The drive-enable is never high while output enable is low, nor within T_REL of output enable rising.
- R5: Define WP as the largest of ceil(T_WP/T_CLK), ceil(T_DS/T_CLK) and ceil(T_AW/T_CLK). For a write, output enable stays high throughout. Chip enable falls one cycle before write enable, write enable stays low for exactly WP cycles, and write enable is never low while chip enable is high.
- R6: For a write, the drive-enable is high from the accepting edge until one cycle after write enable rises, which is WP+2 cycles in all. The address and the write data do not change while the bus is driven. At the end of the write, data has been stable for at least T_DS and the address and chip enable for at least T_AW.
- R7: After a write, req_ready returns WP+2 edges after the accepting edge. The addressed word then holds the written data.
- R8: Write enable and output enable are never low at the same time.
- R9: Address, data and direction are captured on the accepting edge. Changes to req_addr, req_wdata and req_write during an operation have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host offers a request |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | DW | Read data |
| mem_addr | output | AW | Memory address pins |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | DW | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive-enable for the data pads |
| mem_dq_in | input | DW | Data seen on the memory bus |

## Verification
The bench memory model returns garbage until the access time has passed since the last change of address, chip enable or output enable. A read window one cycle too short therefore hands the host a wrong word. At each write-enable rising edge the bench times the pulse, the data setup, the address setup and the chip-enable setup. A sequencer that drops the setup cycle, or lets write enable overlap output enable, fails those checks. The bench counts write pulses while req_valid is held high, so a design that takes a request twice is caught. It also changes the host inputs during an operation to expose a design that fails to capture them. A reset during a write pulse must return every strobe high at once.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_RD_WAIT    = 3'd1,
    ST_RD_CAP     = 3'd2,
    ST_WR_SETUP   = 3'd3,
    ST_WR_PULSE   = 3'd4,
    ST_WR_RECOVER = 3'd5,
    ST_TURN       = 3'd6
  } ctl_state_e;

  // whole cycles covering a time in picoseconds
  function automatic int unsigned cyc_ceil(input int unsigned t_ps, input int unsigned clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
`timescale 1ns/1ps
module sram_ctl_timer #(
  parameter int unsigned CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - CW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_ctl_fsm.sv
`timescale 1ns/1ps
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int unsigned CW     = 2,
  parameter int unsigned RD_CYC = 2,
  parameter int unsigned WP_CYC = 2,
  parameter int unsigned TA_CYC = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          tmr_done,
  output ctl_state_e    state,
  output ctl_state_e    state_n,
  output logic          accept,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          req_ready
);

  localparam logic [CW-1:0] RD_LOAD = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] WP_LOAD = CW'(WP_CYC - 1);
  localparam logic [CW-1:0] TA_LOAD = CW'(TA_CYC - 1);

  ctl_state_e state_q;
  logic       ready_q;

  assign accept = req_valid && ready_q && (state_q == ST_IDLE);

  // next-state process
  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_IDLE:       if (accept) state_n = req_write ? ST_WR_SETUP : ST_RD_WAIT;
      ST_RD_WAIT:    if (tmr_done) state_n = ST_RD_CAP;
      ST_RD_CAP:     state_n = ST_TURN;
      ST_TURN:       if (tmr_done) state_n = ST_IDLE;
      ST_WR_SETUP:   state_n = ST_WR_PULSE;
      ST_WR_PULSE:   if (tmr_done) state_n = ST_WR_RECOVER;
      ST_WR_RECOVER: state_n = ST_IDLE;
      default:       state_n = ST_IDLE;
    endcase
  end

  // interval timer is reloaded on every state change
  always_comb begin
    tmr_load = (state_n != state_q);
    unique case (state_n)
      ST_RD_WAIT:  tmr_val = RD_LOAD;
      ST_WR_PULSE: tmr_val = WP_LOAD;
      ST_TURN:     tmr_val = TA_LOAD;
      default:     tmr_val = '0;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ready_q <= 1'b0;
    end else begin
      state_q <= state_n;
      ready_q <= (state_n == ST_IDLE);
    end
  end

  assign state     = state_q;
  assign req_ready = ready_q;

  p_accept_drops_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
  p_ready_only_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (state_q == ST_IDLE));
  p_cap_follows_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD_CAP) |-> ($past(state_q) == ST_RD_WAIT));

endmodule

// File: rtl/sram_ctl_pins.sv
`timescale 1ns/1ps
module sram_ctl_pins
  import sram_ctl_pkg::*;
#(
  parameter int unsigned AW = 19,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctl_state_e    state,
  input  ctl_state_e    state_n,
  input  logic          accept,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] mem_dq_in,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);

  logic ce_d, oe_d, we_d, drv_d, cap_en;
  logic ce_n_q, oe_n_q, we_n_q, drv_q, rsp_v_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;

  // pin levels for the coming state, registered below so they are glitch free
  always_comb begin
    ce_d   = state_n inside {ST_RD_WAIT, ST_RD_CAP, ST_WR_SETUP, ST_WR_PULSE, ST_WR_RECOVER};
    oe_d   = state_n inside {ST_RD_WAIT, ST_RD_CAP};
    we_d   = (state_n == ST_WR_PULSE);
    drv_d  = state_n inside {ST_WR_SETUP, ST_WR_PULSE, ST_WR_RECOVER};
    cap_en = (state == ST_RD_CAP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      drv_q   <= 1'b0;
      rsp_v_q <= 1'b0;
    end else begin
      ce_n_q  <= !ce_d;
      oe_n_q  <= !oe_d;
      we_n_q  <= !we_d;
      drv_q   <= drv_d;
      rsp_v_q <= cap_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (cap_en) begin
      rdata_q <= mem_dq_in;
    end
  end

  assign mem_addr   = addr_q;
  assign mem_ce_n   = ce_n_q;
  assign mem_oe_n   = oe_n_q;
  assign mem_we_n   = we_n_q;
  assign mem_dq_out = wdata_q;
  assign mem_dq_oe  = drv_q;
  assign rsp_valid  = rsp_v_q;
  assign rsp_rdata  = rdata_q;

  p_we_oe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));
  p_we_inside_ce_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n);
  p_ce_leads_we_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> !$past(mem_ce_n));
  p_drive_covers_we_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_dq_oe);
  p_drive_after_we_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_dq_oe);
  p_hold_while_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> ($stable(mem_dq_out) && $stable(mem_addr)));
  p_no_drive_on_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);
  p_addr_hold_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n && $past(!mem_oe_n)) |-> $stable(mem_addr));
  p_rsp_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/sram_ctl.sv
`timescale 1ns/1ps
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int unsigned AW       = 19,
  parameter int unsigned DW       = 16,
  parameter int unsigned CLK_PS   = 10000,
  parameter int unsigned T_ACC_PS = 15000,
  parameter int unsigned T_OE_PS  = 7000,
  parameter int unsigned T_WP_PS  = 10000,
  parameter int unsigned T_DS_PS  = 7000,
  parameter int unsigned T_AW_PS  = 10000,
  parameter int unsigned T_REL_PS = 7000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);

  localparam int unsigned RD_CYC  = umax(1, umax(cyc_ceil(T_ACC_PS, CLK_PS), cyc_ceil(T_OE_PS, CLK_PS)));
  localparam int unsigned WP_CYC  = umax(1, umax(cyc_ceil(T_WP_PS, CLK_PS),
                                         umax(cyc_ceil(T_DS_PS, CLK_PS), cyc_ceil(T_AW_PS, CLK_PS))));
  localparam int unsigned TA_CYC  = umax(1, cyc_ceil(T_REL_PS, CLK_PS));
  localparam int unsigned MAX_CYC = umax(RD_CYC, umax(WP_CYC, TA_CYC));
  localparam int unsigned CW      = umax(1, $clog2(MAX_CYC + 1));

  // asynchronous assertion, synchronous release
  logic rst_s1, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  ctl_state_e    state, state_n;
  logic          accept, tmr_load, tmr_done;
  logic [CW-1:0] tmr_val;

  sram_ctl_fsm #(
    .CW(CW), .RD_CYC(RD_CYC), .WP_CYC(WP_CYC), .TA_CYC(TA_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .tmr_done  (tmr_done),
    .state     (state),
    .state_n   (state_n),
    .accept    (accept),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .req_ready (req_ready)
  );

  sram_ctl_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  sram_ctl_pins #(.AW(AW), .DW(DW)) u_pins (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .state      (state),
    .state_n    (state_n),
    .accept     (accept),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

  p_idle_pins_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe));

endmodule

// File: tb/tb_sram_ctl.sv
`timescale 1ns/1ps
module tb_sram_ctl;

  localparam int CLK_PS = 5000;
  localparam real TCLK  = 5.0;
  localparam real T_ACC = 15.0;
  localparam real T_OE  = 7.0;
  localparam real T_WP  = 10.0;
  localparam real T_DS  = 7.0;
  localparam real T_AW  = 10.0;
  localparam real T_REL = 7.0;

  function automatic int up(input int ps);
    return (ps + CLK_PS - 1) / CLK_PS;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD = mx(up(15000), up(7000));
  localparam int WP = mx(up(10000), mx(up(7000), up(10000)));
  localparam int TA = up(7000);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, rsp_valid, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [15:0] rsp_rdata, mem_dq_out;
  logic [18:0] mem_addr;
  logic [15:0] mem_dq_in = 16'hBAD1;

  always #2.5 clk = ~clk;

  sram_ctl #(.CLK_PS(CLK_PS)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  bit mon_en = 1'b0;
  int wr_count = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [15:0] mem [logic [18:0]];
  realtime t_ce_fall = -100.0, t_oe_fall = -100.0, t_oe_rise = -100.0;
  realtime t_addr = -100.0, t_we_fall = -100.0, t_dq_chg = -100.0;

  always @(negedge mem_ce_n) t_ce_fall = $realtime;
  always @(negedge mem_oe_n) t_oe_fall = $realtime;
  always @(posedge mem_oe_n) t_oe_rise = $realtime;
  always @(mem_addr) t_addr = $realtime;
  always @(mem_dq_out or mem_dq_oe) t_dq_chg = $realtime;

  function automatic logic [15:0] word_at(input logic [18:0] a);
    return mem.exists(a) ? mem[a] : 16'hE0E0;
  endfunction

  // data only becomes valid once every access time has elapsed
  always @(negedge clk) begin
    if (!mem_ce_n && !mem_oe_n && mem_we_n &&
        ($realtime >= t_ce_fall + T_ACC) && ($realtime >= t_addr + T_ACC) &&
        ($realtime >= t_oe_fall + T_OE))
      mem_dq_in <= word_at(mem_addr);
    else
      mem_dq_in <= 16'hBAD1;
  end

  always @(negedge mem_we_n) begin
    if (mon_en) begin
      chk(($realtime - t_ce_fall > TCLK - 0.01) && ($realtime - t_ce_fall < TCLK + 0.01),
          "R5", "chip enable one cycle ahead of write enable", 32'(int'($realtime - t_ce_fall)), 32'(int'(TCLK)));
      chk(mem_oe_n === 1'b1, "R5", "output enable high at write start", 32'(mem_oe_n), 32'd1);
    end
  end

  always @(posedge mem_we_n) begin
    if (mon_en && mem_ce_n === 1'b0) begin
      chk($realtime - t_we_fall >= T_WP, "R5", "write pulse width ns", 32'(int'($realtime - t_we_fall)), 32'(int'(T_WP)));
      chk($realtime - t_dq_chg >= T_DS, "R6", "data setup to write end ns", 32'(int'($realtime - t_dq_chg)), 32'(int'(T_DS)));
      chk($realtime - t_addr >= T_AW, "R6", "address setup to write end ns", 32'(int'($realtime - t_addr)), 32'(int'(T_AW)));
      chk($realtime - t_ce_fall >= T_AW, "R6", "chip enable to write end ns", 32'(int'($realtime - t_ce_fall)), 32'(int'(T_AW)));
      chk(mem_oe_n === 1'b1 && mem_dq_oe === 1'b1, "R8", "oe high and bus driven at write end",
          {30'd0, mem_oe_n, mem_dq_oe}, 32'd3);
      mem[mem_addr] = mem_dq_out;
      wr_count++;
    end
  end
  always @(negedge mem_we_n) t_we_fall = $realtime;

  // bus contention watch
  always @(negedge clk) begin
    if (mon_en && mem_dq_oe === 1'b1 &&
        (mem_oe_n !== 1'b1 || $realtime < t_oe_rise + T_REL))
      chk(1'b0, "R4", "bus driven while memory may still drive", 32'(mem_oe_n), 32'd1);
    if (mon_en && mem_we_n === 1'b0 && mem_oe_n === 1'b0)
      chk(1'b0, "R8", "write and output enable both low", 32'd0, 32'd1);
  end

  // ---------------- operation task ----------------
  task automatic do_op(input bit wr, input logic [18:0] a, input logic [15:0] d, input bit hold,
                       output int lat_rsp, output int lat_rdy, output logic [15:0] rd,
                       output int we_cyc, output int drv_cyc);
    lat_rsp = -1; lat_rdy = -1; rd = 16'h0; we_cyc = 0; drv_cyc = 0;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (req_ready !== 1'b1) @(negedge clk);
    @(negedge clk);
    if (!hold) req_valid = 1'b0;
    req_write = !wr; req_addr = ~a; req_wdata = ~d;
    for (int k = 1; k <= 60; k++) begin
      if (rsp_valid) begin lat_rsp = k; rd = rsp_rdata; end
      if (!mem_we_n) we_cyc++;
      if (mem_dq_oe) drv_cyc++;
      if (req_ready) begin lat_rdy = k; req_valid = 1'b0; break; end
      @(negedge clk);
    end
  endtask

  // write flag, address, data (expected data for reads)
  localparam int NV = 10;
  localparam logic [35:0] VEC [NV] = '{
    {1'b1, 19'h00000, 16'hA5C3},
    {1'b1, 19'h7FFFF, 16'hFFFF},
    {1'b1, 19'h12345, 16'h0000},
    {1'b0, 19'h00000, 16'hA5C3},
    {1'b0, 19'h7FFFF, 16'hFFFF},
    {1'b1, 19'h00000, 16'h3C5A},
    {1'b0, 19'h12345, 16'h0000},
    {1'b0, 19'h00000, 16'h3C5A},
    {1'b1, 19'h2AAAA, 16'h5555},
    {1'b0, 19'h2AAAA, 16'h5555}
  };

  initial begin
    int lr, ly, wc, dc, w0;
    logic [15:0] rd;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R1", "strobes idle in reset",
        {28'd0, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 32'hE);
    chk(!req_ready && !rsp_valid, "R1", "ready and rsp low in reset", {30'd0, req_ready, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready === 1'b1, "R1", "ready after reset release", 32'(req_ready), 32'd1);
    mon_en = 1'b1;

    for (int i = 0; i < NV; i++) begin
      do_op(VEC[i][35], VEC[i][34:16], VEC[i][15:0], 1'b0, lr, ly, rd, wc, dc);
      if (VEC[i][35]) begin
        chk(ly == WP + 3, "R7", "write ready latency", 32'(ly), 32'(WP + 3));
        chk(wc == WP, "R5", "write enable low cycles", 32'(wc), 32'(WP));
        chk(dc == WP + 2, "R6", "drive-enable cycles", 32'(dc), 32'(WP + 2));
        chk(word_at(VEC[i][34:16]) == VEC[i][15:0], "R9", "stored word uses captured request",
            32'(word_at(VEC[i][34:16])), 32'(VEC[i][15:0]));
      end else begin
        chk(lr == RD + 2, "R3", "read response cycle", 32'(lr), 32'(RD + 2));
        chk(rd == VEC[i][15:0], "R3", "read data", 32'(rd), 32'(VEC[i][15:0]));
        chk(ly == RD + 2 + TA, "R4", "ready after turnaround", 32'(ly), 32'(RD + 2 + TA));
        chk(wc == 0 && dc == 0, "R4", "no write or drive during read", 32'(wc + dc), 32'd0);
      end
      @(negedge clk);
      chk(!rsp_valid, "R3", "response is a single pulse", 32'(rsp_valid), 32'd0);
    end

    // R2: req_valid held high through a write starts exactly one operation
    w0 = wr_count;
    do_op(1'b1, 19'h00777, 16'h1234, 1'b1, lr, ly, rd, wc, dc);
    repeat (3) @(negedge clk);
    chk(wr_count - w0 == 1, "R2", "one write for held request", 32'(wr_count - w0), 32'd1);
    chk(word_at(19'h00777) == 16'h1234, "R9", "held request data", 32'(word_at(19'h00777)), 32'h1234);

    // R1: reset in the middle of a write pulse
    mon_en = 1'b0;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 19'h00100; req_wdata = 16'h0F0F;
    while (req_ready !== 1'b1) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (mem_we_n !== 1'b0) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !req_ready, "R1", "strobes released by reset",
        {27'd0, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ready}, 32'h1C);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_en = 1'b1;
    chk(req_ready === 1'b1, "R1", "ready after mid-write reset", 32'(req_ready), 32'd1);

    // read after reset still works and write-after-read turnaround
    do_op(1'b0, 19'h00777, 16'h0, 1'b0, lr, ly, rd, wc, dc);
    chk(rd == 16'h1234, "R3", "read after reset", 32'(rd), 32'h1234);
    do_op(1'b1, 19'h00778, 16'h8001, 1'b0, lr, ly, rd, wc, dc);
    chk(word_at(19'h00778) == 16'h8001, "R7", "write right after read", 32'(word_at(19'h00778)), 32'h8001);

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule